// File: doc/BRIEF.md
# Ratiometric Gated Pulse-Count Converter

This block turns the pulse train of a synchronous voltage-to-frequency converter into a binary code. It counts the converter's output pulses over a gate interval. The gate is timed from the same reference clock that drives the converter, so clock jitter and drift cancel out and the result is a pure frequency ratio. The gate lasts twice the code count N, and a full-scale input runs at half the reference clock. A full-scale input therefore produces N pulses in one gate.

A host selects N, which may be a power of two or a decimal count such as 10000, and pulses `start`. The pulse input arrives through an isolating path and is not aligned to the clock. It is captured and synchronised, and only its rising edges are counted. When the gate closes, the count and an overflow indication are latched and `done` pulses once.

Top module: `ratio_pulse_converter`

## Requirements
- R1: A synchronous reset, including one that arrives in the middle of a gate, leaves `busy`, `done`, `result` and `overflow` all at 0 from the clock edge that samples it.
- R2: A `start` that is accepted at clock edge s latches `codes_n` and raises `busy` for exactly 2·N edges (s through s+2N−1). At edge s+2N, `busy` falls and `done` is 1 for that single cycle.
- R3: A rising edge of `pulse_in` is a low level at clock edge k−1 followed by a high level at edge k. It is counted if and only if s−1 ≤ k ≤ s+2N−2. This window accounts for the two-stage synchroniser and makes the count at the gate boundary deterministic.
- R4: The pulse count saturates at N−1. If any further edge falls inside the window, `overflow` is latched as 1; otherwise `overflow` is 0.
- R5: A `start` that arrives while `busy` is 1 is ignored, and the running gate keeps its original end edge.
- R6: Changes on `codes_n` while `busy` is 1 have no effect on the gate length or on the saturation limit.
- R7: A `start` with `codes_n` below 2 or above MAX_CODES is ignored, and `busy` stays 0.
- R8: `result` and `overflow` hold their last latched values until the next gate closes, including while a new gate is running.
- R9: Both power-of-two and decimal code counts work (for example 16, 10 and 20). The largest count without overflow is N−1.
- R10: A full-scale input, with one rising edge every 2 clocks, reads N−1 with `overflow` set. Half of full scale reads N/2 with `overflow` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, shared with the converter |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a conversion |
| codes_n | input | CODE_W (17) | Number of codes N for the conversion |
| pulse_in | input | 1 | Asynchronous frequency pulses from the converter |
| result | output | RES_W (16) | Latched count, in the range 0 to N−1 |
| overflow | output | 1 | Count exceeded N−1 in the last gate |
| done | output | 1 | One-cycle strobe when a new result is latched |
| busy | output | 1 | Gate is open |

## Verification
The bench builds the block with its default parameters: MAX_CODES of 65536, which gives a 17-bit `codes_n`, and two synchroniser stages. This keeps the full width of the code and gate counters and the upper range check in place. Stimulus uses small N values (2, 5, 8, 10, 16, 20, 37), so each gate lasts only tens of cycles. With gates that short, every gate-boundary edge position, saturation at N−1 and the one-cycle `done` strobe can be reached many times within a short run. Values of `codes_n` of 0, 1 and 65537 exercise the range rejection at both ends.

// File: rtl/vgc_pkg.sv
package vgc_pkg;
   typedef enum logic {GATE_IDLE = 1'b0, GATE_OPEN = 1'b1} gate_state_e;
   localparam int unsigned SYNC_MIN = 2;
endpackage

// File: rtl/vgc_sync_edge.sv
module vgc_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last_lvl;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[0] <= 1'b0;
               else     chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[g] <= 1'b0;
               else     chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) last_lvl <= 1'b0;
      else     last_lvl <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~last_lvl;

   // R3: a detected edge lasts one cycle
   a_r3_rise_single: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise);
endmodule

// File: rtl/vgc_gate_timer.sv
module vgc_gate_timer
   import vgc_pkg::*;
#(
   parameter int unsigned CODE_W    = 17,
   parameter int unsigned MIN_CODES = 2,
   parameter int unsigned MAX_CODES = 65536
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [CODE_W-1:0] codes_n,
   output logic              launch,
   output logic              open,
   output logic              last,
   output logic [CODE_W-1:0] codes_lat
);
   localparam int unsigned GATE_W = CODE_W + 1;

   gate_state_e       state;
   logic [GATE_W-1:0] gate_cnt;
   logic [GATE_W-1:0] gate_len;
   logic              codes_ok;

   assign codes_ok = (codes_n >= CODE_W'(MIN_CODES)) && (codes_n <= CODE_W'(MAX_CODES));
   assign open     = (state == GATE_OPEN);
   assign launch   = start && !open && codes_ok;
   assign gate_len = {codes_lat, 1'b0};
   assign last     = open && (gate_cnt == gate_len - GATE_W'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= GATE_IDLE;
         gate_cnt  <= '0;
         codes_lat <= '0;
      end else if (launch) begin
         state     <= GATE_OPEN;
         gate_cnt  <= '0;
         codes_lat <= codes_n;
      end else if (last) begin
         state     <= GATE_IDLE;
      end else if (open) begin
         gate_cnt  <= gate_cnt + GATE_W'(1);
      end
   end

   // R2: the gate counter never passes the gate length
   a_r2_gate_bound: assert property (@(posedge clk) disable iff (rst)
      open |-> (gate_cnt < gate_len));
   // R2: an open gate advances by one each cycle until its last one
   a_r2_gate_step: assert property (@(posedge clk) disable iff (rst)
      (open && !last) |=> (open && gate_cnt == $past(gate_cnt) + GATE_W'(1)));
   // R5, R6: the latched code count is stable while the gate is open
   a_r6_codes_held: assert property (@(posedge clk) disable iff (rst)
      (open && !last) |=> $stable(codes_lat));
   // R7: a gate only opens with an in-range code count
   a_r7_valid_open: assert property (@(posedge clk) disable iff (rst)
      $rose(open) |-> ($past(codes_n) >= CODE_W'(MIN_CODES) &&
                       $past(codes_n) <= CODE_W'(MAX_CODES)));
endmodule

// File: rtl/vgc_pulse_accum.sv
module vgc_pulse_accum #(
   parameter int unsigned CODE_W = 17,
   parameter int unsigned RES_W  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clear,
   input  logic              active,
   input  logic              count,
   input  logic              close,
   input  logic [CODE_W-1:0] limit,
   output logic [RES_W-1:0]  result,
   output logic              overflow
);
   logic [RES_W-1:0] cnt, nxt_cnt;
   logic             ovf_run, nxt_ovf, full;

   assign full = (CODE_W'(cnt) == limit - CODE_W'(1));

   always_comb begin
      nxt_cnt = cnt;
      nxt_ovf = ovf_run;
      if (count) begin
         if (full) nxt_ovf = 1'b1;
         else      nxt_cnt = cnt + RES_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt      <= '0;
         ovf_run  <= 1'b0;
         result   <= '0;
         overflow <= 1'b0;
      end else begin
         if (clear) begin
            cnt     <= '0;
            ovf_run <= 1'b0;
         end else begin
            cnt     <= nxt_cnt;
            ovf_run <= nxt_ovf;
         end
         if (close) begin
            result   <= nxt_cnt;
            overflow <= nxt_ovf;
         end
      end
   end

   // R4: the running count stays below the code count
   a_r4_sat_bound: assert property (@(posedge clk) disable iff (rst)
      active |-> (CODE_W'(cnt) < limit));
   // R4: overflow stays set for the rest of the gate
   a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
      (ovf_run && !clear) |=> ovf_run);
   // R8: the latched outputs change only when a gate closes
   a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
      !close |=> ($stable(result) && $stable(overflow)));
endmodule

// File: rtl/ratio_pulse_converter.sv
module ratio_pulse_converter
   import vgc_pkg::*;
#(
   parameter int unsigned MAX_CODES   = 65536,
   parameter int unsigned MIN_CODES   = 2,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned CODE_W     = $clog2(MAX_CODES + 1),
   localparam int unsigned RES_W      = $clog2(MAX_CODES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [CODE_W-1:0] codes_n,
   input  logic              pulse_in,
   output logic [RES_W-1:0]  result,
   output logic              overflow,
   output logic              done,
   output logic              busy
);
   generate
      if (SYNC_STAGES < SYNC_MIN) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (MIN_CODES < 2) begin : g_bad_min
         $error("MIN_CODES must be at least 2");
      end
      if (MAX_CODES < MIN_CODES) begin : g_bad_max
         $error("MAX_CODES must not be below MIN_CODES");
      end
   endgenerate

   logic              rise, launch, open, last;
   logic [CODE_W-1:0] codes_lat;

   vgc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .async_in(pulse_in), .rise(rise)
   );

   vgc_gate_timer #(.CODE_W(CODE_W), .MIN_CODES(MIN_CODES), .MAX_CODES(MAX_CODES)) u_gate (
      .clk(clk), .rst(rst), .start(start), .codes_n(codes_n),
      .launch(launch), .open(open), .last(last), .codes_lat(codes_lat)
   );

   vgc_pulse_accum #(.CODE_W(CODE_W), .RES_W(RES_W)) u_accum (
      .clk(clk), .rst(rst), .clear(launch), .active(open),
      .count(rise && open), .close(last), .limit(codes_lat),
      .result(result), .overflow(overflow)
   );

   always_ff @(posedge clk) begin
      if (rst) done <= 1'b0;
      else     done <= last;
   end

   assign busy = open;

   // R2: done is a single-cycle strobe
   a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   // R2: done follows the end of a gate
   a_r2_done_after_busy: assert property (@(posedge clk) disable iff (rst)
      done |-> (!busy && $past(busy)));
   // R1: the first cycle after reset is idle
   a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!busy && !done));
endmodule

// File: tb/ratio_pulse_converter_test.sv
`timescale 1ns/1ps
module ratio_pulse_converter_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [16:0] codes_n = 17'd16;
   logic        pulse_in = 1'b0;
   logic [15:0] result;
   logic        overflow, done, busy;

   ratio_pulse_converter uut (
      .clk(clk), .rst(rst), .start(start), .codes_n(codes_n),
      .pulse_in(pulse_in), .result(result), .overflow(overflow),
      .done(done), .busy(busy)
   );

   always #4 clk = ~clk;

   int   cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int   checks = 0;
   int   fails  = 0;
   bit   finished = 0;
   int   rises[$];
   logic prev_p = 1'b0;
   logic s_busy, s_done, s_ovf;
   logic [15:0] s_res;
   int   last_res = 0;
   logic last_ovf = 1'b0;
   bit   have_last = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // samples outputs after the previous edge, then drives for the next edge
   task automatic step(input logic p, input logic st, input int n);
      @(negedge clk);
      s_busy = busy; s_done = done; s_res = result; s_ovf = overflow;
      pulse_in = p; start = st; codes_n = 17'(n);
      if (p && !prev_p) rises.push_back(cyc + 1);
      prev_p = p;
   endtask

   function automatic int in_window(input int s, input int n);
      int c = 0;
      foreach (rises[i]) if (rises[i] >= s - 1 && rises[i] <= s + 2*n - 2) c++;
      return c;
   endfunction

   function automatic logic pat(input int mode, input int j, input int pos);
      case (mode)
         1: return (j % 2 == 0);
         2: return (j % 4 == 0);
         3: return 1'($urandom_range(0, 1));
         4: return (j == pos);
         default: return 1'b0;
      endcase
   endfunction

   // mode: 0 none, 1 full scale, 2 half scale, 3 random, 4 single edge at pos
   task automatic run_conv(input int n, input int mode, input int pos, input bit disturb, input string tag);
      int s, exp_cnt, exp_res;
      logic exp_ovf;
      bit busy_ok = 1;
      rises.delete();
      for (int j = -3; j < 0; j++) step(pat(mode == 4 ? 4 : 0, j, pos), 1'b0, n);
      step(pat(mode, 0, pos), 1'b1, n);
      s = cyc + 1;
      for (int j = 1; j <= 2*n + 1; j++) begin
         step(pat(mode, j, pos), (disturb && j == 3) ? 1'b1 : 1'b0, disturb ? n + 7 : n);
         if (j <= 2*n && s_busy !== 1'b1) busy_ok = 0;
         if (have_last && j == n)
            chk(s_res == 16'(last_res) && s_ovf == last_ovf, "R8 result held during next gate", int'(s_res), last_res);
      end
      exp_cnt = in_window(s, n);
      exp_res = (exp_cnt > n - 1) ? n - 1 : exp_cnt;
      exp_ovf = (exp_cnt > n - 1);
      chk(busy_ok, {tag, " R2 busy for 2N cycles"}, 0, 1);
      chk(s_busy == 1'b0 && s_done == 1'b1, {tag, " R2 done at end of gate"}, int'({s_busy, s_done}), 1);
      chk(s_res == 16'(exp_res), {tag, " R3 R4 result"}, int'(s_res), exp_res);
      chk(s_ovf == exp_ovf, {tag, " R4 overflow"}, int'(s_ovf), int'(exp_ovf));
      step(1'b0, 1'b0, n);
      chk(s_done == 1'b0, {tag, " R2 done single cycle"}, int'(s_done), 0);
      last_res = exp_res; last_ovf = exp_ovf; have_last = 1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int n_list[7] = '{2, 5, 8, 10, 16, 20, 37};
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      step(1'b0, 1'b0, 16);
      chk(s_busy == 0 && s_done == 0 && s_res == 0 && s_ovf == 0, "R1 reset state", int'(s_res), 0);

      // R10 full scale and half scale, R9 power-of-two N
      run_conv(16, 1, 0, 0, "R10 full-scale N=16");
      run_conv(16, 2, 0, 0, "R10 half-scale N=16");
      chk(last_res == 8 && !last_ovf, "R10 half scale reads N/2", last_res, 8);

      // R9 decimal N, highest count without overflow
      run_conv(10, 4, 1, 0, "R9 N=10 single");
      run_conv(20, 2, 0, 0, "R9 N=20 half-scale");
      run_conv(10, 1, 0, 0, "R9 R4 N=10 full-scale");

      // R3 gate boundary edges, N=8
      run_conv(8, 4, 14, 0, "R3 edge k=s+2N-2 counted");
      chk(last_res == 1, "R3 last in-window edge", last_res, 1);
      run_conv(8, 4, 15, 0, "R3 edge k=s+2N-1 dropped");
      chk(last_res == 0, "R3 first out-of-window edge", last_res, 0);
      run_conv(8, 4, -1, 0, "R3 edge k=s-1 counted");
      chk(last_res == 1, "R3 pre-start edge in window", last_res, 1);
      run_conv(8, 4, -2, 0, "R3 edge k=s-2 dropped");
      chk(last_res == 0, "R3 early edge outside window", last_res, 0);

      // R5 restart ignored, R6 N change ignored
      run_conv(8, 1, 0, 1, "R5 R6 disturbed gate");

      // R7 out-of-range N ignored
      foreach (n_list[i]) if (0) $display("%0d", n_list[i]);
      step(1'b0, 1'b1, 1); step(1'b0, 1'b0, 1);
      chk(s_busy == 0, "R7 N=1 start ignored", int'(s_busy), 0);
      step(1'b0, 1'b1, 0); step(1'b0, 1'b0, 0);
      chk(s_busy == 0, "R7 N=0 start ignored", int'(s_busy), 0);
      step(1'b0, 1'b1, 65537); step(1'b0, 1'b0, 65537);
      chk(s_busy == 0, "R7 N above max ignored", int'(s_busy), 0);
      chk(s_res == 16'(last_res), "R8 result held while idle", int'(s_res), last_res);

      // random runs
      for (int r = 0; r < 30; r++) begin
         int n = n_list[$urandom_range(0, 6)];
         run_conv(n, 3, 0, 0, "R3 R4 random");
         repeat ($urandom_range(0, 4)) step(1'($urandom_range(0, 1)), 1'b0, n);
      end

      // R1 reset in mid-gate
      rises.delete();
      step(1'b0, 1'b1, 20);
      repeat (5) step(1'b1, 1'b0, 20);
      @(negedge clk); rst = 1'b1; pulse_in = 1'b0; prev_p = 1'b0; start = 1'b0;
      @(negedge clk);
      chk(busy == 0 && done == 0 && result == 0 && overflow == 0, "R1 reset mid-gate clears outputs", int'(result), 0);
      rst = 1'b0;
      step(1'b0, 1'b0, 20);
      chk(s_busy == 0, "R1 idle after reset release", int'(s_busy), 0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule